// File: doc/BRIEF.md
# Counted Loop Branch Controller

This block keeps the two counters that steer a software-pipelined counted loop: the remaining-iteration count and the drain count. Before entering the loop, software writes the iteration count minus one into the first counter and the number of pipeline stages into the second. Each loop-closing branch then sends a one-cycle request. The block looks at both counters and sorts the request into one of four cases: steady state, drain, final drain, or finished. It then updates the counters and reports whether the branch is taken.

Two branch forms exist. The loop-back form is taken while the loop is still running or draining. The leave form uses the opposite sense. For every resolved branch, the block also outputs the bit to shift into the lowest rotating predicate and a single-cycle rotate pulse for the rename-base logic elsewhere. All results are registered and appear exactly one clock after the request.

Top module: `loop_branch_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both counters read zero and `rsp_valid`, `taken`, `pred_in` and `rotate` are all 0.
- R2: A high `iter_we` or `drain_we` writes the matching data input into its counter, visible on `iter_cnt` or `drain_cnt` one cycle later. Each write enable acts independently.
- R3: Steady case (iteration count nonzero): the iteration count drops by one and the drain count holds. `pred_in` is 1 and `rotate` is 1.
- R4: Drain case (iteration count zero, drain count above 1): the iteration count holds at zero and the drain count drops by one. `pred_in` is 0 and `rotate` is 1.
- R5: Final-drain case (iteration count zero, drain count exactly 1): the drain count becomes 0. `pred_in` is 0 and `rotate` is still 1.
- R6: Finished case (both counts zero): both counters hold and `pred_in` is 0. `rotate` stays 0, but `rsp_valid` is still 1.
- R7: `br_kind` = 0 selects the loop-back form, which is taken in the steady and drain cases and not taken in the final-drain and finished cases. `br_kind` = 1 selects the leave form, which has the exact inverse sense in all four cases.
- R8: A branch request in a cycle where either write enable is high is dropped. No response appears, the written counter takes the written value, and the other counter holds.
- R9: `rsp_valid` is high for exactly one cycle, one cycle after each accepted request, and is low in every cycle that follows no accepted request. This holds even when requests arrive back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| iter_we | input | 1 | Write enable for the iteration counter |
| iter_wdata | input | 64 | Value written into the iteration counter |
| drain_we | input | 1 | Write enable for the drain counter |
| drain_wdata | input | 64 | Value written into the drain counter |
| br_req | input | 1 | One-cycle loop-branch request |
| br_kind | input | 1 | 0 = loop-back form, 1 = leave form |
| iter_cnt | output | 64 | Current iteration count |
| drain_cnt | output | 64 | Current drain count |
| rsp_valid | output | 1 | Branch result valid |
| taken | output | 1 | Branch is taken |
| pred_in | output | 1 | Bit to shift into the lowest rotating predicate |
| rotate | output | 1 | One-cycle pulse that advances the rename base |

## Verification
The properties assume that `br_kind` is stable in any cycle where `br_req` is high, and that the counters change only through the write enables or through resolved branches. The bench drives every input on the falling clock edge and holds it for a full cycle, so both assumptions hold. It loads counters only through the write ports, including near the full-width maximum. It issues requests both back to back and with gaps, and it exercises both forms of the load/branch collision.

// File: rtl/loop_branch_pkg.sv
`timescale 1ns/1ps
// Shared types for the counted loop branch controller.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package loop_branch_pkg;
    // Which of the four counter states a branch request falls in.
    typedef enum logic [1:0] {
        LB_STEADY = 2'd0,
        LB_DRAIN  = 2'd1,
        LB_FINAL  = 2'd2,
        LB_DONE   = 2'd3
    } lb_case_t;

    // Encoding of the branch form input.
    typedef enum logic {
        BR_LOOPBACK = 1'b0,
        BR_LEAVE    = 1'b1
    } br_form_t;
endpackage

// File: rtl/loop_branch_decide.sv
`timescale 1ns/1ps
// Combinational decision for one loop-branch request.
// Classifies the counter state into four cases and derives branch sense,
// predicate bit, rotate request and counter decrement requests.
// Assumes the counter inputs are the current register values.
module loop_branch_decide
    import loop_branch_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic [CNT_W-1:0] iter_q,
    input  logic [CNT_W-1:0] drain_q,
    input  logic             kind,
    output lb_case_t         sel_case,
    output logic             take,
    output logic             pred_bit,
    output logic             rot_req,
    output logic             iter_dec,
    output logic             drain_dec
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Pick the case from the two counts, steady state first.
    always_comb begin
        if (iter_q != '0)
            sel_case = LB_STEADY;
        else if (drain_q > ONE)
            sel_case = LB_DRAIN;
        else if (drain_q == ONE)
            sel_case = LB_FINAL;
        else
            sel_case = LB_DONE;
    end

    // Derive all per-case actions from the selected case and branch form.
    always_comb begin
        logic keep_going;
        keep_going = (sel_case == LB_STEADY) || (sel_case == LB_DRAIN);
        take       = (br_form_t'(kind) == BR_LEAVE) ? !keep_going : keep_going;
        pred_bit   = (sel_case == LB_STEADY);
        rot_req    = (sel_case != LB_DONE);
        iter_dec   = (sel_case == LB_STEADY);
        drain_dec  = (sel_case == LB_DRAIN) || (sel_case == LB_FINAL);
    end
endmodule

// File: rtl/loop_count_reg.sv
`timescale 1ns/1ps
// One loadable down-counter register.
// A load takes priority over a decrement. Assumes the caller never asks
// for a decrement of zero (the decision logic guarantees this).
module loop_count_reg #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] q
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    // Hold, load or step down the count on each clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (dec)
            q <= q - STEP;
    end
endmodule

// File: rtl/loop_branch_ctrl.sv
`timescale 1ns/1ps
// Counted loop branch controller (top).
// Holds the iteration and drain counters, resolves loop-back and leave
// branches, and registers taken/predicate/rotate one cycle after a request.
// Assumes br_kind is valid whenever br_req is high. A request that meets
// a counter write in the same cycle is dropped.
module loop_branch_ctrl
    import loop_branch_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iter_we,
    input  logic [CNT_W-1:0] iter_wdata,
    input  logic             drain_we,
    input  logic [CNT_W-1:0] drain_wdata,
    input  logic             br_req,
    input  logic             br_kind,
    output logic [CNT_W-1:0] iter_cnt,
    output logic [CNT_W-1:0] drain_cnt,
    output logic             rsp_valid,
    output logic             taken,
    output logic             pred_in,
    output logic             rotate
);
    lb_case_t sel_case;
    logic     take_c, pred_c, rot_c, iter_dec_c, drain_dec_c;
    logic     accept;

    // A request is accepted only when no counter write competes with it.
    always_comb accept = br_req && !iter_we && !drain_we;

    loop_branch_decide #(.CNT_W(CNT_W)) u_decide (
        .iter_q    (iter_cnt),
        .drain_q   (drain_cnt),
        .kind      (br_kind),
        .sel_case  (sel_case),
        .take      (take_c),
        .pred_bit  (pred_c),
        .rot_req   (rot_c),
        .iter_dec  (iter_dec_c),
        .drain_dec (drain_dec_c)
    );

    loop_count_reg #(.CNT_W(CNT_W)) u_iter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (iter_we),
        .load_val (iter_wdata),
        .dec      (accept && iter_dec_c),
        .q        (iter_cnt)
    );

    loop_count_reg #(.CNT_W(CNT_W)) u_drain (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (drain_we),
        .load_val (drain_wdata),
        .dec      (accept && drain_dec_c),
        .q        (drain_cnt)
    );

    // Register the branch result for one cycle after an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            taken     <= 1'b0;
            pred_in   <= 1'b0;
            rotate    <= 1'b0;
        end else begin
            rsp_valid <= accept;
            taken     <= accept && take_c;
            pred_in   <= accept && pred_c;
            rotate    <= accept && rot_c;
        end
    end
endmodule

// File: rtl/loop_branch_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for loop_branch_ctrl, bound to every instance.
// Relates requests and counter values at the ports to the next cycle.
module loop_branch_ctrl_chk #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iter_we,
    input logic [CNT_W-1:0] iter_wdata,
    input logic             drain_we,
    input logic [CNT_W-1:0] drain_wdata,
    input logic             br_req,
    input logic             br_kind,
    input logic [CNT_W-1:0] iter_cnt,
    input logic [CNT_W-1:0] drain_cnt,
    input logic             rsp_valid,
    input logic             taken,
    input logic             pred_in,
    input logic             rotate
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    logic go;
    assign go = br_req && !iter_we && !drain_we;

    assert_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (go && iter_cnt != '0) |=> (iter_cnt == $past(iter_cnt) - ONE &&
            drain_cnt == $past(drain_cnt) && pred_in && rotate));

    assert_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (go && iter_cnt == '0 && drain_cnt > ONE) |=> (iter_cnt == '0 &&
            drain_cnt == $past(drain_cnt) - ONE && !pred_in && rotate));

    assert_final_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (go && iter_cnt == '0 && drain_cnt == ONE) |=>
            (drain_cnt == '0 && iter_cnt == '0 && !pred_in && rotate));

    assert_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (go && iter_cnt == '0 && drain_cnt == '0) |=>
            (drain_cnt == '0 && iter_cnt == '0 && !pred_in && !rotate && rsp_valid));

    assert_sense_R7: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (taken == ($past(br_kind) ^
            ($past(iter_cnt) != '0 || $past(drain_cnt) > ONE))));

    assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (br_req && (iter_we || drain_we)) |=> !rsp_valid);

    assert_iter_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        iter_we |=> iter_cnt == $past(iter_wdata));

    assert_drain_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        drain_we |=> drain_cnt == $past(drain_wdata));

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (!rsp_valid && !rotate && !taken && !pred_in));

    assert_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> rsp_valid);
endmodule

bind loop_branch_ctrl loop_branch_ctrl_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/loop_branch_ctrl_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected results, a monitor pops them.
module loop_branch_ctrl_test;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         iter_we = 1'b0, drain_we = 1'b0;
    logic [W-1:0] iter_wdata = '0, drain_wdata = '0;
    logic         br_req = 1'b0, br_kind = 1'b0;
    logic [W-1:0] iter_cnt, drain_cnt;
    logic         rsp_valid, taken, pred_in, rotate;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    typedef struct {
        logic         tk;
        logic         pr;
        logic         rt;
        logic [W-1:0] ic;
        logic [W-1:0] dc;
        string        rq;
    } exp_t;
    exp_t sb[$];

    logic [W-1:0] m_iter = '0, m_drain = '0;

    always #10 clk = ~clk;

    loop_branch_ctrl #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .iter_we(iter_we), .iter_wdata(iter_wdata),
        .drain_we(drain_we), .drain_wdata(drain_wdata),
        .br_req(br_req), .br_kind(br_kind),
        .iter_cnt(iter_cnt), .drain_cnt(drain_cnt),
        .rsp_valid(rsp_valid), .taken(taken), .pred_in(pred_in), .rotate(rotate)
    );

    task automatic chk(input bit ok, input string rq, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Write counters through the ports, then confirm (R2).
    task automatic load(input logic [W-1:0] ic, input logic [W-1:0] dc);
        iter_we = 1'b1; drain_we = 1'b1; iter_wdata = ic; drain_wdata = dc;
        @(negedge clk);
        iter_we = 1'b0; drain_we = 1'b0;
        m_iter = ic; m_drain = dc;
        chk(iter_cnt == ic, "R2 iter load", iter_cnt, ic);
        chk(drain_cnt == dc, "R2 drain load", drain_cnt, dc);
    endtask

    // Drive one branch request and push its expected result.
    task automatic branch(input logic kind, input string rq);
        exp_t e;
        logic cont;
        cont = 1'b0;
        e.pr = 1'b0; e.rt = 1'b1;
        if (m_iter != 0) begin
            m_iter = m_iter - 1; cont = 1'b1; e.pr = 1'b1;
        end else if (m_drain > 1) begin
            m_drain = m_drain - 1; cont = 1'b1;
        end else if (m_drain == 1) begin
            m_drain = 0;
        end else begin
            e.rt = 1'b0;
        end
        e.tk = kind ? !cont : cont;
        e.ic = m_iter; e.dc = m_drain; e.rq = rq;
        sb.push_back(e);
        br_req = 1'b1; br_kind = kind;
        @(negedge clk);
        br_req = 1'b0;
    endtask

    // Request colliding with a write: must be dropped (R8).
    task automatic collide(input bit which, input logic [W-1:0] v);
        br_req = 1'b1; br_kind = 1'b0;
        if (which) begin drain_we = 1'b1; drain_wdata = v; end
        else begin iter_we = 1'b1; iter_wdata = v; end
        @(negedge clk);
        br_req = 1'b0; iter_we = 1'b0; drain_we = 1'b0;
        if (which) m_drain = v; else m_iter = v;
        chk(rsp_valid == 1'b0, "R8 no response", W'(rsp_valid), 0);
        chk(iter_cnt == m_iter, "R8 iter", iter_cnt, m_iter);
        chk(drain_cnt == m_drain, "R8 drain", drain_cnt, m_drain);
    endtask

    // Monitor: compare each response with the scoreboard head (R9).
    always @(negedge clk) begin
        if (rst_n && !finished && rsp_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R9 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(taken == e.tk, {e.rq, " R7 taken"}, W'(taken), W'(e.tk));
                chk(pred_in == e.pr, {e.rq, " pred"}, W'(pred_in), W'(e.pr));
                chk(rotate == e.rt, {e.rq, " rotate"}, W'(rotate), W'(e.rt));
                chk(iter_cnt == e.ic, {e.rq, " iter"}, iter_cnt, e.ic);
                chk(drain_cnt == e.dc, {e.rq, " drain"}, drain_cnt, e.dc);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(iter_cnt == 0 && drain_cnt == 0, "R1 counters", iter_cnt | drain_cnt, 0);
        chk({rsp_valid, taken, pred_in, rotate} == 4'b0, "R1 outputs",
            W'({rsp_valid, taken, pred_in, rotate}), 0);

        // Four iterations, three stages, loop-back form: R3 R4 R5 R6 back to back
        load(3, 3);
        for (int i = 0; i < 7; i++) branch(1'b0, "R3/R4/R5/R6 loopback");
        @(negedge clk);
        // R9: no request, no response
        chk(rsp_valid == 1'b0, "R9 idle", W'(rsp_valid), 0);

        // Leave form with gaps between requests (R7)
        load(1, 2);
        for (int i = 0; i < 4; i++) begin
            branch(1'b1, "R7 leave");
            @(negedge clk);
        end

        // Final drain from exactly one (R5), then finished twice (R6)
        load(0, 1);
        branch(1'b0, "R5 final");
        branch(1'b0, "R6 done");
        branch(1'b1, "R6 done leave");

        // Near full width counts (R3, R4)
        load({W{1'b1}}, {W{1'b1}});
        branch(1'b0, "R3 max");
        branch(1'b1, "R3 max leave");
        load(0, {W{1'b1}});
        branch(1'b0, "R4 max");
        branch(1'b1, "R4 max leave");

        // R8: write wins over a branch in the same cycle
        load(5, 4);
        collide(1'b0, 0);
        collide(1'b1, 9);
        branch(1'b0, "R4 after collide");
        @(negedge clk);
        @(negedge clk);
        chk(sb.size() == 0, "R9 all responses seen", W'(sb.size()), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule